// File: doc/BRIEF.md
# I/O Space Wait-State Generator

This block runs single accesses to a separate 2048-location I/O address space. An access starts on a read or write request. The block then drives an active-low I/O select, the matching active-low read or write strobe, and the access address on a 14-bit external address bus. It holds these signals for a programmable number of extra cycles and ends the access with a one-cycle done pulse. The peripheral gives no handshake, so the length of every access comes from the block's own wait-state settings.

The space is cut into four equal regions by the top two address bits. Each region has its own 3-bit wait-state setting, written through a small configuration port. A slow peripheral can therefore sit in one region and fast ones in another without slowing each other down. Requests are level signals. While an access is running, the block raises busy and accepts nothing new. A request that stays asserted starts as soon as the current access completes, so it is never lost.

Top module: `io_wait_gen`

## Requirements
- R1: After reset, the select, read strobe and write strobe are high, done and busy are low, the bus address is 0, and all four wait-state settings hold 7.
- R2: The address bits 10:9 pick the setting. Value 0 covers 0x000-0x1FF, 1 covers 0x200-0x3FF, 2 covers 0x400-0x5FF and 3 covers 0x600-0x7FF.
- R3: The select and the active strobe stay low for exactly 1+N consecutive cycles, where N is the setting chosen for that access (N=0 gives one cycle).
- R4: Done is high for exactly one cycle: the first cycle after the select returns high.
- R5: During an access, bus address bits 10:0 equal the request address captured at the start, and bits 13:11 are 0. The bus holds steady for the whole access and reads 0 when idle.
- R6: A read drives only the read strobe and a write drives only the write strobe. When both requests are high on a starting cycle, the read goes first.
- R7: Busy is high in every cycle the select is low. Requests seen while busy do not start an access. A request still held when the access ends starts on the next clock edge, so its select goes low in the cycle after the done pulse.
- R8: A configuration write with enable high stores the 3-bit value into the setting named by the 2-bit index. The new value applies only to accesses that start later, and an access already running keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request (level) |
| wr_req | input | 1 | Write request (level) |
| io_addr | input | 11 | I/O address of the request |
| cfg_we | input | 1 | Wait-state setting write enable |
| cfg_idx | input | 2 | Index of the setting to write |
| cfg_wdata | input | 3 | New wait-state count |
| io_sel_n | output | 1 | Active-low I/O space select |
| rd_strb_n | output | 1 | Active-low read strobe |
| wr_strb_n | output | 1 | Active-low write strobe |
| bus_addr | output | 14 | External address bus |
| done | output | 1 | One-cycle access-complete pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the block with its default parameters: an 11-bit address, a 14-bit bus, four regions and 3-bit settings. These values let it reach both the shortest access (N=0) and the longest (N=7, the reset value). It also probes the first and last address of every region, so each decode boundary is exercised. A request held across a busy access and a setting rewritten in the middle of an access show that requests are deferred without loss and that a running access keeps its length.

// File: rtl/io_wait_pkg.sv
package io_wait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } io_state_t;

  // number of regions the address space is divided into
  function automatic int region_count(input int region_bits);
    return 1 << region_bits;
  endfunction

endpackage

// File: rtl/io_wait_regfile.sv
module io_wait_regfile #(
  parameter int REGION_BITS = 2,
  parameter int WAIT_W      = 3,
  localparam int REGIONS    = io_wait_pkg::region_count(REGION_BITS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [REGION_BITS-1:0]             wr_idx,
  input  logic [WAIT_W-1:0]                  wr_val,
  output logic [REGIONS-1:0][WAIT_W-1:0]     waits
);

  localparam logic [WAIT_W-1:0] RESET_WAIT = '1;

  for (genvar g = 0; g < REGIONS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        waits[g] <= RESET_WAIT;
      end else if (wr_en && (wr_idx == REGION_BITS'(g))) begin
        waits[g] <= wr_val;
      end
    end
  end

endmodule

// File: rtl/io_wait_region_dec.sv
module io_wait_region_dec #(
  parameter int ADDR_W      = 11,
  parameter int REGION_BITS = 2,
  parameter int WAIT_W      = 3,
  localparam int REGIONS    = io_wait_pkg::region_count(REGION_BITS)
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [REGIONS-1:0][WAIT_W-1:0] waits,
  output logic [WAIT_W-1:0]              sel_wait
);

  logic [REGION_BITS-1:0] region;

  always_comb begin
    region   = addr[ADDR_W-1 -: REGION_BITS];
    sel_wait = waits[region];
  end

endmodule

// File: rtl/io_wait_seq.sv
module io_wait_seq
  import io_wait_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BUS_W  = 14,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WAIT_W-1:0] wait_val,
  output logic              sel_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BUS_W-1:0]  bus_addr,
  output logic              done,
  output logic              busy
);

  localparam int PAD_W = BUS_W - ADDR_W;

  io_state_t         state;
  logic [WAIT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      remain   <= '0;
      sel_n    <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      bus_addr <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (rd_req || wr_req) begin
          state    <= rd_req ? ST_READ : ST_WRITE;
          remain   <= wait_val;
          sel_n    <= 1'b0;
          rd_n     <= ~rd_req;
          wr_n     <= rd_req;
          bus_addr <= {{PAD_W{1'b0}}, addr};
        end
      end else if (remain == '0) begin
        state    <= ST_IDLE;
        sel_n    <= 1'b1;
        rd_n     <= 1'b1;
        wr_n     <= 1'b1;
        bus_addr <= '0;
        done     <= 1'b1;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen #(
  parameter int ADDR_W      = 11,
  parameter int BUS_W       = 14,
  parameter int REGION_BITS = 2,
  parameter int WAIT_W      = 3,
  localparam int REGIONS    = io_wait_pkg::region_count(REGION_BITS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_req,
  input  logic                   wr_req,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   cfg_we,
  input  logic [REGION_BITS-1:0] cfg_idx,
  input  logic [WAIT_W-1:0]      cfg_wdata,
  output logic                   io_sel_n,
  output logic                   rd_strb_n,
  output logic                   wr_strb_n,
  output logic [BUS_W-1:0]       bus_addr,
  output logic                   done,
  output logic                   busy
);

  logic [REGIONS-1:0][WAIT_W-1:0] waits;
  logic [WAIT_W-1:0]              sel_wait;

  io_wait_regfile #(
    .REGION_BITS(REGION_BITS),
    .WAIT_W     (WAIT_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_we),
    .wr_idx(cfg_idx),
    .wr_val(cfg_wdata),
    .waits (waits)
  );

  io_wait_region_dec #(
    .ADDR_W     (ADDR_W),
    .REGION_BITS(REGION_BITS),
    .WAIT_W     (WAIT_W)
  ) u_dec (
    .addr    (io_addr),
    .waits   (waits),
    .sel_wait(sel_wait)
  );

  io_wait_seq #(
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W),
    .WAIT_W(WAIT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .addr    (io_addr),
    .wait_val(sel_wait),
    .sel_n   (io_sel_n),
    .rd_n    (rd_strb_n),
    .wr_n    (wr_strb_n),
    .bus_addr(bus_addr),
    .done    (done),
    .busy    (busy)
  );

endmodule

// File: rtl/io_wait_gen_chk.sv
module io_wait_gen_chk #(
  parameter int ADDR_W = 11,
  parameter int BUS_W  = 14,
  parameter int WAIT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             io_sel_n,
  input logic             rd_strb_n,
  input logic             wr_strb_n,
  input logic [BUS_W-1:0] bus_addr,
  input logic             done,
  input logic             busy
);

  localparam int MAX_LEN = (1 << WAIT_W);
  localparam int LEN_W   = WAIT_W + 2;

  logic [LEN_W-1:0] low_len;

  always_ff @(posedge clk) begin
    if (rst || io_sel_n) low_len <= '0;
    else                 low_len <= low_len + 1'b1;
  end

  // R3
  sel_len_chk: assert property (@(posedge clk) disable iff (rst)
    low_len <= LEN_W'(MAX_LEN));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(io_sel_n) |-> done);

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_addr[BUS_W-1:ADDR_W] == '0);

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!io_sel_n && $past(!io_sel_n)) |-> $stable(bus_addr));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_strb_n && !wr_strb_n));

  // R7
  busy_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !io_sel_n |-> busy);

endmodule

bind io_wait_gen io_wait_gen_chk #(
  .ADDR_W(ADDR_W),
  .BUS_W (BUS_W),
  .WAIT_W(WAIT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_sel_n (io_sel_n),
  .rd_strb_n(rd_strb_n),
  .wr_strb_n(wr_strb_n),
  .bus_addr (bus_addr),
  .done     (done),
  .busy     (busy)
);

// File: tb/io_wait_gen_bench.sv
`timescale 1ns/1ps
module io_wait_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0, wr_req = 1'b0;
  logic [10:0] io_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [2:0]  cfg_wdata = '0;
  logic        io_sel_n, rd_strb_n, wr_strb_n, done, busy;
  logic [13:0] bus_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  io_wait_gen u_io_wait_gen (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .io_addr(io_addr),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .io_sel_n(io_sel_n), .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
    .bus_addr(bus_addr), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = 3'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Called at the first negedge with select low; counts the access length.
  task automatic measure(input bit is_rd, input logic [10:0] a,
                         input int n_exp, input string req);
    int len = 0;
    bit strb_ok = 1'b1, addr_ok = 1'b1, busy_ok = 1'b1;
    while (!io_sel_n && len < 40) begin
      if (is_rd ? (rd_strb_n || !wr_strb_n) : (wr_strb_n || !rd_strb_n)) strb_ok = 1'b0;
      if (bus_addr != {3'b000, a}) addr_ok = 1'b0;
      if (!busy) busy_ok = 1'b0;
      len++;
      @(negedge clk);
    end
    chk(len == n_exp + 1, req, "R3 select length", len, n_exp + 1);
    chk(strb_ok, "R6", "strobe matches access kind", int'(strb_ok), 1);
    chk(addr_ok, "R5", "bus address during access", int'(addr_ok), 1);
    chk(busy_ok, "R7", "busy during access", int'(busy_ok), 1);
    chk(done == 1'b1, "R4", "done after select rises", int'(done), 1);
    chk(bus_addr == 14'd0, "R5", "bus idle value", int'(bus_addr), 0);
    @(negedge clk);
    chk(done == 1'b0, "R4", "done single cycle", int'(done), 0);
  endtask

  task automatic access(input bit is_rd, input logic [10:0] a,
                        input int n_exp, input string req);
    @(negedge clk);
    rd_req = is_rd; wr_req = !is_rd; io_addr = a;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    measure(is_rd, a, n_exp, req);
  endtask

  task automatic t_reset();
    chk(io_sel_n && rd_strb_n && wr_strb_n, "R1", "strobes idle after reset",
        int'({io_sel_n, rd_strb_n, wr_strb_n}), 7);
    chk(!done && !busy, "R1", "done/busy low after reset", int'({done, busy}), 0);
    chk(bus_addr == 14'd0, "R1", "bus address after reset", int'(bus_addr), 0);
    access(1'b1, 11'h7FF, 7, "R1");
    access(1'b0, 11'h000, 7, "R1");
  endtask

  task automatic t_regions();
    cfg_write(0, 0); cfg_write(1, 2); cfg_write(2, 5); cfg_write(3, 1);
    access(1'b1, 11'h000, 0, "R2");
    access(1'b1, 11'h1FF, 0, "R2");
    access(1'b0, 11'h200, 2, "R2");
    access(1'b1, 11'h3FF, 2, "R2");
    access(1'b1, 11'h400, 5, "R2");
    access(1'b0, 11'h5FF, 5, "R2");
    access(1'b0, 11'h600, 1, "R8");
    access(1'b1, 11'h7FF, 1, "R8");
  endtask

  task automatic t_collide();
    // both requests together: read first, write held and started later
    @(negedge clk);
    rd_req = 1'b1; wr_req = 1'b1; io_addr = 11'h250;
    @(negedge clk);
    rd_req = 1'b0;
    measure(1'b1, 11'h250, 2, "R6");
    chk(!io_sel_n && !wr_strb_n, "R7", "held write starts after done",
        int'({io_sel_n, wr_strb_n}), 0);
    wr_req = 1'b0;
    measure(1'b0, 11'h250, 2, "R7");
    @(negedge clk);
    chk(io_sel_n, "R7", "no extra access after request drops", int'(io_sel_n), 1);
  endtask

  task automatic t_cfg_midaccess();
    @(negedge clk);
    wr_req = 1'b1; io_addr = 11'h480;
    @(negedge clk);
    wr_req = 1'b0;
    fork
      measure(1'b0, 11'h480, 5, "R8");
      begin
        cfg_we = 1'b1; cfg_idx = 2'd2; cfg_wdata = 3'd1;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    access(1'b1, 11'h4A0, 1, "R8");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regions();
    t_collide();
    t_cfg_midaccess();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule